// File: doc/BRIEF.md
# Dual-CPU Interrupt Status and Mask Unit

This block gathers up to 64 level-sensitive interrupt sources into a status register, sampled on every clock. It holds a separate set of mask words for each of two CPUs. Each CPU receives one registered request line, high whenever at least one of its unmasked sources is pending. CPU 0's request appears on processor line 2 and CPU 1's on processor line 3 of an 8-bit line vector.

For each CPU, a selector reports the next pending source in round-robin order, so no source has fixed priority. The selector holds a per-CPU pointer. When the CPU acknowledges a reported index, the pointer moves to just past that index and wraps at the source count. A contiguous range of source indices can be marked as cascaded external inputs; indices in that range are also reported as an external number relative to the range start.

Software reaches the status and mask words through a simple read/write register port. A separate disable strobe clears one source in both CPUs' mask sets at once.

Top module: `irq_stat_mask_unit`

## Requirements
- R1: Each clock edge samples `src_i` into the status register. A status word read shows the value `src_i` had at the previous edge. The status is shared by both CPUs.
- R2: Register address encoding is {cpu, sel, word}: bit 2 selects the CPU (mask only), bit 1 selects mask (1) or status (0), and bit 0 is the word. With 64 sources, source n sits in word (n/32) XOR 1 at bit n mod 32, so sources 32..63 read at word 0.
- R3: After reset, every mask word reads zero, both request lines are low and no index is valid.
- R4: A mask write changes only the addressed CPU's mask word. The other CPU's masks keep their value.
- R5: Bit 2 of `int_line_o` follows CPU 0's pending set and bit 3 follows CPU 1's; the other bits are always 0. A line rises one clock after a mask write enables a captured source, and two clocks after a source input rises.
- R6: The reported index is the first pending source found scanning upward from the CPU's pointer, wrapping at the source count. When that CPU's acknowledge is high while its index is valid, the pointer becomes index+1 modulo the source count. Pointers reset to 0.
- R7: With no unmasked source pending, the valid flag is 0 and an acknowledge leaves the pointer unchanged.
- R8: The two CPUs' pointers advance independently.
- R9: A disable strobe clears the named source's bit in both CPUs' mask sets. It wins over a mask write to the same bit in the same cycle.
- R10: For an index in the cascaded range [40,43], the external flag is 1 and the reported number is index-40. Otherwise the flag is 0 and the number equals the index.
- R11: Writes to a status address are ignored; the status read back is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Level interrupt sources |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address {cpu, sel, word} |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| dis_i | input | 1 | Disable a source in both mask sets |
| dis_idx_i | input | 6 | Source to disable |
| ack_i | input | 2 | Per-CPU acknowledge of the reported index |
| nxt_vld_o | output | 2 | Per-CPU index valid |
| nxt_idx_o | output | 12 | Per-CPU next pending index, 6 bits each |
| nxt_ext_o | output | 2 | Per-CPU flag: index is in the cascaded range |
| nxt_num_o | output | 12 | Per-CPU reported number (external or internal) |
| int_line_o | output | 8 | Processor interrupt lines |

## Verification
A corrupted pointer shows up on the first acknowledge: the next reported index skips or repeats a source compared with the wrapping scan the bench predicts. A swapped word order or a mask bit landing in the wrong CPU shows on the very next register read, and on the request line one clock later. The bench walks a sequence of pending patterns through repeated acknowledges, covering wrap-around, the empty case and the cascaded range. Directed cases then check reset values, line timing, disable priority and pointer independence.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned NUM_CPU    = 2;
  localparam int unsigned LINE_W     = 8;
  localparam int unsigned LINE_BASE  = 2;  // cpu c drives line LINE_BASE + c
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned WSEL_W  = 1,
  parameter int unsigned IDX_W   = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [WSEL_W-1:0]          wr_word_i,
  input  logic [irq_pkg::WORD_W-1:0] wr_data_i,
  input  logic                       clr_en_i,
  input  logic [IDX_W-1:0]           clr_idx_i,
  output logic [NUM_SRC-1:0]         mask_o
);
  localparam int unsigned NUM_WORDS = NUM_SRC / irq_pkg::WORD_W;

  logic [NUM_SRC-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en_i) begin
      for (int p = 0; p < NUM_WORDS; p++) begin
        if (int'(wr_word_i) == p)
          mask_d[(p ^ (NUM_WORDS-1))*irq_pkg::WORD_W +: irq_pkg::WORD_W] = wr_data_i;
      end
    end
    // disable takes precedence over a same-cycle write
    if (clr_en_i) mask_d[clr_idx_i] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // R9
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> !mask_o[$past(clr_idx_i)]);
endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned EXT_LO  = 40,
  parameter int unsigned EXT_HI  = 43,
  parameter bit          EXT_EN  = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               adv_i,
  output logic               vld_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               ext_o,
  output logic [IDX_W-1:0]   num_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] j;

  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    j     = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      j = ptr_q + IDX_W'(k);  // wraps: NUM_SRC is a power of two
      if (!vld_o && pend_i[j]) begin
        vld_o = 1'b1;
        idx_o = j;
      end
    end
  end

  always_comb begin
    ext_o = 1'b0;
    num_o = idx_o;
    if (EXT_EN && int'(idx_o) >= int'(EXT_LO) && int'(idx_o) <= int'(EXT_HI)) begin
      ext_o = 1'b1;
      num_o = idx_o - IDX_W'(EXT_LO);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ptr_q <= '0;
    else if (adv_i && vld_o)  ptr_q <= idx_o + 1'b1;
  end

  // R6
  pick_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> pend_i[idx_o]);
  // R6
  ptr_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i[ptr_q] |-> (idx_o == ptr_q));
  // R7
  empty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |=> $stable(ptr_q));
  // R7
  vld_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o == (pend_i != '0));
endmodule

// File: rtl/irq_stat_mask_unit.sv
module irq_stat_mask_unit #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned EXT_LO  = 40,
  parameter int unsigned EXT_HI  = 43,
  parameter bit          EXT_EN  = 1'b1,
  localparam int unsigned NUM_WORDS = NUM_SRC / irq_pkg::WORD_W,
  localparam int unsigned WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned ADDR_W    = WSEL_W + 2,
  localparam int unsigned IDX_W     = $clog2(NUM_SRC),
  localparam int unsigned NCPU      = irq_pkg::NUM_CPU
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SRC-1:0]         src_i,
  input  logic                       reg_we_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [irq_pkg::WORD_W-1:0] reg_wdata_i,
  output logic [irq_pkg::WORD_W-1:0] reg_rdata_o,
  input  logic                       dis_i,
  input  logic [IDX_W-1:0]           dis_idx_i,
  input  logic [NCPU-1:0]            ack_i,
  output logic [NCPU-1:0]            nxt_vld_o,
  output logic [NCPU*IDX_W-1:0]      nxt_idx_o,
  output logic [NCPU-1:0]            nxt_ext_o,
  output logic [NCPU*IDX_W-1:0]      nxt_num_o,
  output logic [irq_pkg::LINE_W-1:0] int_line_o
);
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] mask_w [NCPU];
  logic [NUM_SRC-1:0] pend_w [NCPU];
  logic [NCPU-1:0]    irq_q;

  logic              a_cpu, a_msel;
  logic [WSEL_W-1:0] a_word;
  assign a_cpu  = reg_addr_i[ADDR_W-1];
  assign a_msel = reg_addr_i[ADDR_W-2];
  assign a_word = reg_addr_i[WSEL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= src_i;
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    irq_mask_bank #(.NUM_SRC(NUM_SRC), .WSEL_W(WSEL_W), .IDX_W(IDX_W)) u_mask (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (reg_we_i && a_msel && (int'(a_cpu) == c)),
      .wr_word_i (a_word),
      .wr_data_i (reg_wdata_i),
      .clr_en_i  (dis_i),
      .clr_idx_i (dis_idx_i),
      .mask_o    (mask_w[c])
    );

    assign pend_w[c] = stat_q & mask_w[c];

    irq_rr_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .EXT_LO(EXT_LO),
                  .EXT_HI(EXT_HI), .EXT_EN(EXT_EN)) u_pick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pend_i (pend_w[c]),
      .adv_i  (ack_i[c]),
      .vld_o  (nxt_vld_o[c]),
      .idx_o  (nxt_idx_o[c*IDX_W +: IDX_W]),
      .ext_o  (nxt_ext_o[c]),
      .num_o  (nxt_num_o[c*IDX_W +: IDX_W])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q[c] <= 1'b0;
      else         irq_q[c] <= |pend_w[c];
    end

    // R5
    line_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int_line_o[irq_pkg::LINE_BASE + c] |-> $past((stat_q & mask_w[c]) != '0));
  end

  always_comb begin
    int_line_o = '0;
    for (int c = 0; c < NCPU; c++) int_line_o[irq_pkg::LINE_BASE + c] = irq_q[c];
  end

  always_comb begin
    logic [NUM_SRC-1:0] vec;
    vec = a_msel ? mask_w[a_cpu] : stat_q;
    reg_rdata_o = '0;
    for (int p = 0; p < NUM_WORDS; p++) begin
      if (int'(a_word) == p)
        reg_rdata_o = vec[(p ^ (NUM_WORDS-1))*irq_pkg::WORD_W +: irq_pkg::WORD_W];
    end
  end

  // R10
  ext_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nxt_ext_o[0] |-> (nxt_idx_o[IDX_W-1:0] == nxt_num_o[IDX_W-1:0] + IDX_W'(EXT_LO)));
endmodule

// File: tb/tb_irq_stat_mask_unit.sv
`timescale 1ns/1ps
module tb_irq_stat_mask_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src_i = '0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        dis_i = 1'b0;
  logic [5:0]  dis_idx_i = '0;
  logic [1:0]  ack_i = '0;
  logic [1:0]  nxt_vld_o;
  logic [11:0] nxt_idx_o;
  logic [1:0]  nxt_ext_o;
  logic [11:0] nxt_num_o;
  logic [7:0]  int_line_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  irq_stat_mask_unit dut (.*);

  typedef struct packed {
    logic [63:0] src;
    logic        vld;
    logic [5:0]  idx;
    logic        ext;
    logic [5:0]  num;
  } vec_t;

  localparam vec_t TBL [11] = '{
    '{64'h0000_0000_0000_0220, 1'b1, 6'd5,  1'b0, 6'd5},
    '{64'h0000_0000_0000_0220, 1'b1, 6'd9,  1'b0, 6'd9},
    '{64'h0000_0000_0000_0220, 1'b1, 6'd5,  1'b0, 6'd5},
    '{64'h8000_0000_0000_0004, 1'b1, 6'd63, 1'b0, 6'd63},
    '{64'h0000_0000_0000_0001, 1'b1, 6'd0,  1'b0, 6'd0},
    '{64'h0000_0000_0000_0000, 1'b0, 6'd0,  1'b0, 6'd0},
    '{64'h0000_0200_0000_0002, 1'b1, 6'd1,  1'b0, 6'd1},
    '{64'h0000_0200_0000_0002, 1'b1, 6'd41, 1'b1, 6'd1},
    '{64'h0004_0900_0000_0000, 1'b1, 6'd43, 1'b1, 6'd3},
    '{64'h0004_0900_0000_0000, 1'b1, 6'd50, 1'b0, 6'd50},
    '{64'h0004_0900_0000_0000, 1'b1, 6'd40, 1'b1, 6'd0}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #0.5;
    d = reg_rdata_o;
  endtask

  task automatic pulse_ack(int c);
    @(negedge clk_i); ack_i[c] = 1'b1;
    @(negedge clk_i); ack_i = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 reset state
    rd(3'b010, d); check("R3 mask0 w0", d, 0);
    rd(3'b111, d); check("R3 mask1 w1", d, 0);
    check("R3 lines", int_line_o, 0);
    check("R3 vld", nxt_vld_o, 0);

    // R1 / R2 capture and word order
    @(negedge clk_i); src_i = 64'h0000_0002_0000_0000;  // source 33
    @(negedge clk_i);
    rd(3'b000, d); check("R1 R2 status word0 holds src 32..63", d, 32'h2);
    rd(3'b001, d); check("R2 status word1 holds src 0..31", d, 32'h0);

    // R11 status write ignored
    wr(3'b000, 32'hFFFF_FFFF);
    rd(3'b000, d); check("R11 status unchanged", d, 32'h2);

    // R4 / R5 mask write on cpu1 and line timing
    wr(3'b110, 32'h2);
    check("R5 line3 not yet", int_line_o[3], 0);
    @(negedge clk_i);
    check("R5 line3 one clock after mask", int_line_o[3], 1);
    check("R5 line2 stays low, other bits zero", int_line_o & 8'hF7, 0);
    rd(3'b010, d); check("R4 cpu0 mask untouched", d, 0);
    rd(3'b110, d); check("R4 cpu1 mask written", d, 32'h2);

    // R8 cpu1 picker
    check("R8 cpu1 vld", nxt_vld_o, 2'b10);
    check("R8 cpu1 idx", nxt_idx_o[11:6], 33);
    pulse_ack(1);  // cpu1 pointer -> 34

    // R9 disable clears both sets
    @(negedge clk_i); dis_i = 1'b1; dis_idx_i = 6'd33;
    @(negedge clk_i); dis_i = 1'b0;
    rd(3'b110, d); check("R9 cpu1 bit cleared", d, 0);
    @(negedge clk_i);
    check("R9 line3 falls", int_line_o[3], 0);

    // R9 disable wins over same-cycle write (source 0 = word1 bit0)
    @(negedge clk_i);
    reg_addr_i = 3'b011; reg_wdata_i = 32'h1; reg_we_i = 1'b1;
    dis_i = 1'b1; dis_idx_i = 6'd0;
    @(negedge clk_i); reg_we_i = 1'b0; dis_i = 1'b0;
    rd(3'b011, d); check("R9 disable beats write", d, 0);

    // R5 source path: two clocks from input to line
    @(negedge clk_i); src_i = '0;
    wr(3'b010, 32'hFFFF_FFFF);
    wr(3'b011, 32'hFFFF_FFFF);
    @(negedge clk_i);
    check("R5 line2 low with no source", int_line_o[2], 0);
    src_i = 64'h80;
    @(negedge clk_i);
    check("R5 line2 low after capture edge", int_line_o[2], 0);
    @(negedge clk_i);
    check("R5 line2 high second edge", int_line_o[2], 1);

    // R6 R7 R10 table walk on cpu0 (pointer still 0)
    foreach (TBL[i]) begin
      @(negedge clk_i); src_i = TBL[i].src;
      @(negedge clk_i);
      check($sformatf("R7 vld entry %0d", i), nxt_vld_o[0], TBL[i].vld);
      if (TBL[i].vld) begin
        check($sformatf("R6 idx entry %0d", i), nxt_idx_o[5:0], TBL[i].idx);
        check($sformatf("R10 ext entry %0d", i), nxt_ext_o[0], TBL[i].ext);
        check($sformatf("R10 num entry %0d", i), nxt_num_o[5:0], TBL[i].num);
      end
      ack_i[0] = 1'b1;
      @(negedge clk_i); ack_i = '0;
    end

    // R8 pointers independent: cpu0 at 41, cpu1 at 34
    wr(3'b110, 32'hFFFF_FFFF);
    wr(3'b111, 32'hFFFF_FFFF);
    src_i = 64'h0000_0100_0000_0020;
    @(negedge clk_i);
    check("R8 cpu0 wraps to 5", nxt_idx_o[5:0], 5);
    check("R8 cpu1 picks 40", nxt_idx_o[11:6], 40);
    check("R10 cpu1 ext", nxt_ext_o[1], 1);
    check("R10 cpu1 num", nxt_num_o[11:6], 0);

    finish_run();
  end
endmodule